// File: doc/BRIEF.md
# Interrupt Message Write Generator

This block turns interrupts into memory writes. When the domain configuration selects message delivery and the global enable is set, it takes one pending, enabled interrupt source and issues a single address/data write on a valid/ready request bus. The written data is the source's identity number. The address is a configured base plus a page offset chosen by the target hart and guest index. Software can also inject a message through a generate-message register. That request waits in the block and goes out ahead of any source-driven message.

The pending and enable vectors are held outside the block. When a source's message is accepted, the block pulses that source's clear line in the same cycle, and the owner of the pending vector drops the bit at that edge. The byte-order bit sets the byte order of the message data and of the configuration readback word. The readback word carries a fixed marker byte, so software can detect the byte order from it.

Top module: `msgWriteGen`

## Requirements
- R1: After reset, busValid, busy, pendClr and the status bit (bit 12) of genRead are all 0.
- R2: cfgRead, in little-endian form, is 0x80 in bits 31:24, copies cfgWord bits 8 (enable), 2 (message mode) and 0 (big-endian), and has all other bits 0. When cfgWord bit 0 is 1, cfgRead is that word with its four bytes reversed.
- R3: No message is launched while cfgWord bit 8 is 0 or cfgWord bit 2 is 0. Requests wait until both bits are 1.
- R4: A source message uses the target word's hart index in bits 31:18, guest index in bits 17:12 and identity in bits 10:0. The address is msiBase + (hart << 12) + (guest << 12), and the data is the identity zero-extended to 32 bits.
- R5: When cfgWord bit 0 is 1 at launch, the message data is the 32-bit data word with its bytes reversed. When the bit is 0, the data word is sent unchanged.
- R6: Among sources that are both pending and enabled, the lowest-numbered source is sent first. A source that is pending but not enabled never produces a message.
- R7: pendClr is one-hot on the sent source's bit exactly in the cycle where busValid and busReady are both 1 for a source message. It is zero in every other cycle.
- R8: While busValid is 1 and busReady is 0, busValid, busAddr and busData hold their values.
- R9: A genWrEn write captures the hart index from bits 31:18 and the identity from bits 10:0. Its message goes to msiBase + (hart << 12) with the identity as data. genRead shows the hart in bits 31:18, the identity in bits 10:0 and the status in bit 12. The status is 1 from the cycle after the write until the message is accepted.
- R10: A genWrEn write made while the status bit reads 1 is ignored.
- R11: A waiting software message is launched before any source-driven message.
- R12: busy is 1 exactly while a message is on the bus or a software request waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWord | input | 32 | Domain configuration (bit 8 enable, bit 2 message mode, bit 0 big-endian) |
| cfgRead | output | 32 | Configuration readback with marker byte, in the selected byte order |
| msiBase | input | 32 | Base address of message writes |
| srcPending | input | NUM_SRC | Pending bit per source (bit 0 = lowest source) |
| srcEnable | input | NUM_SRC | Enable bit per source |
| targetFlat | input | 32*NUM_SRC | Target word per source, source i in bits 32*i+31:32*i |
| pendClr | output | NUM_SRC | Clear pulse for the sent source's pending bit |
| genWrEn | input | 1 | Write strobe of the generate-message register |
| genWrData | input | 32 | Write data of the generate-message register |
| genRead | output | 32 | Generate-message register readback |
| busValid | output | 1 | Write request valid |
| busReady | input | 1 | Write request accepted |
| busAddr | output | 32 | Write address |
| busData | output | 32 | Write data |
| busy | output | 1 | Message in flight or software request waiting |

## Verification
The hardest situation to reach is a software request and several source requests competing at the same time, while a second software write arrives and must be ignored. The bench holds the global enable low, posts the software write and a repeated write, and raises pending bits on several sources. It then enables delivery and checks the order of the messages that come out. It also sweeps every enable mask over a fully pending vector, so both the lowest-first order and the rule that disabled sources never send are checked against every combination.

// File: rtl/msgw_pkg.sv
package msgw_pkg;
  localparam int WORD_W  = 32;
  localparam int ID_W    = 11;
  localparam int HART_W  = 14;
  localparam int GUEST_W = 6;
  localparam int PAGE_SH = 12;
  localparam int BIT_IE  = 8;
  localparam int BIT_DM  = 2;
  localparam int BIT_BE  = 0;
  localparam int BIT_GST = 12;

  typedef struct packed {
    logic       genLatch;
    logic       loadSw;
    logic       loadSrc;
    logic [7:0] srcIdx;
  } ctlStrobes_t;

  function automatic logic [WORD_W-1:0] byteRev(input logic [WORD_W-1:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/msgw_ctrl.sv
module msgw_ctrl
  import msgw_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               msgMode,
  input  logic [NUM_SRC-1:0] srcPending,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic               genWrEn,
  input  logic               busReady,
  output ctlStrobes_t        strb,
  output logic               busValid,
  output logic               genPend,
  output logic               busy,
  output logic [NUM_SRC-1:0] pendClr
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic             srcHit;
  logic [IDX_W-1:0] pick;
  logic             canLaunch;
  logic             accept;
  logic             curIsSw;
  logic [IDX_W-1:0] curIdx;

  always_comb begin
    srcHit = 1'b0;
    pick   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (srcPending[i] && srcEnable[i]) begin
        srcHit = 1'b1;
        pick   = IDX_W'(i);
      end
    end
  end

  assign canLaunch = enable && msgMode && !busValid;
  assign accept    = busValid && busReady;

  always_comb begin
    strb          = '0;
    strb.genLatch = genWrEn && !genPend;
    strb.loadSw   = canLaunch && genPend;
    strb.loadSrc  = canLaunch && !genPend && srcHit;
    strb.srcIdx   = 8'(pick);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busValid <= 1'b0;
      genPend  <= 1'b0;
      curIsSw  <= 1'b0;
      curIdx   <= '0;
    end else begin
      if (strb.genLatch) begin
        genPend <= 1'b1;
      end else if (accept && curIsSw) begin
        genPend <= 1'b0;
      end
      if (accept) begin
        busValid <= 1'b0;
      end else if (strb.loadSw || strb.loadSrc) begin
        busValid <= 1'b1;
        curIsSw  <= strb.loadSw;
        curIdx   <= pick;
      end
    end
  end

  always_comb begin
    pendClr = '0;
    if (accept && !curIsSw) pendClr[curIdx] = 1'b1;
  end

  assign busy = busValid || genPend;
endmodule

// File: rtl/msgw_dp.sv
module msgw_dp
  import msgw_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobes_t               strb,
  input  logic                      genPend,
  input  logic [WORD_W-1:0]         cfgWord,
  input  logic [WORD_W-1:0]         msiBase,
  input  logic [WORD_W*NUM_SRC-1:0] targetFlat,
  input  logic [WORD_W-1:0]         genWrData,
  output logic [WORD_W-1:0]         cfgRead,
  output logic [WORD_W-1:0]         genRead,
  output logic [WORD_W-1:0]         busAddr,
  output logic [WORD_W-1:0]         busData
);
  logic [WORD_W-1:0]  tgt [NUM_SRC];
  logic [HART_W-1:0]  genHart;
  logic [ID_W-1:0]    genId;
  logic [WORD_W-1:0]  selTgt;
  logic [HART_W-1:0]  nxtHart;
  logic [GUEST_W-1:0] nxtGuest;
  logic [ID_W-1:0]    nxtId;
  logic [WORD_W-1:0]  nxtAddr;
  logic [WORD_W-1:0]  rawData;
  logic [WORD_W-1:0]  cfgLe;
  logic               bigEnd;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gUnpack
    assign tgt[g] = targetFlat[WORD_W*g +: WORD_W];
  end

  assign bigEnd = cfgWord[BIT_BE];

  always_comb begin
    cfgLe         = '0;
    cfgLe[31:24]  = 8'h80;
    cfgLe[BIT_IE] = cfgWord[BIT_IE];
    cfgLe[BIT_DM] = cfgWord[BIT_DM];
    cfgLe[BIT_BE] = cfgWord[BIT_BE];
  end
  assign cfgRead = bigEnd ? byteRev(cfgLe) : cfgLe;

  always_comb begin
    selTgt = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (strb.srcIdx == 8'(i)) selTgt = tgt[i];
    end
    if (strb.loadSw) begin
      nxtHart  = genHart;
      nxtGuest = '0;
      nxtId    = genId;
    end else begin
      nxtHart  = selTgt[31:18];
      nxtGuest = selTgt[17:12];
      nxtId    = selTgt[ID_W-1:0];
    end
    nxtAddr = msiBase + (WORD_W'(nxtHart) << PAGE_SH) + (WORD_W'(nxtGuest) << PAGE_SH);
    rawData = WORD_W'(nxtId);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      genHart <= '0;
      genId   <= '0;
      busAddr <= '0;
      busData <= '0;
    end else begin
      if (strb.genLatch) begin
        genHart <= genWrData[31:18];
        genId   <= genWrData[ID_W-1:0];
      end
      if (strb.loadSw || strb.loadSrc) begin
        busAddr <= nxtAddr;
        busData <= bigEnd ? byteRev(rawData) : rawData;
      end
    end
  end

  always_comb begin
    genRead            = '0;
    genRead[31:18]     = genHart;
    genRead[BIT_GST]   = genPend;
    genRead[ID_W-1:0]  = genId;
  end
endmodule

// File: rtl/msgWriteGen.sv
module msgWriteGen
  import msgw_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [31:0]               cfgWord,
  output logic [31:0]               cfgRead,
  input  logic [31:0]               msiBase,
  input  logic [NUM_SRC-1:0]        srcPending,
  input  logic [NUM_SRC-1:0]        srcEnable,
  input  logic [32*NUM_SRC-1:0]     targetFlat,
  output logic [NUM_SRC-1:0]        pendClr,
  input  logic                      genWrEn,
  input  logic [31:0]               genWrData,
  output logic [31:0]               genRead,
  output logic                      busValid,
  input  logic                      busReady,
  output logic [31:0]               busAddr,
  output logic [31:0]               busData,
  output logic                      busy
);
  ctlStrobes_t strb;
  logic        genPend;

  msgw_ctrl #(.NUM_SRC(NUM_SRC)) uCtrl (
    .clk(clk), .rstN(rstN),
    .enable(cfgWord[BIT_IE]), .msgMode(cfgWord[BIT_DM]),
    .srcPending(srcPending), .srcEnable(srcEnable),
    .genWrEn(genWrEn), .busReady(busReady),
    .strb(strb), .busValid(busValid), .genPend(genPend),
    .busy(busy), .pendClr(pendClr)
  );

  msgw_dp #(.NUM_SRC(NUM_SRC)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .genPend(genPend),
    .cfgWord(cfgWord), .msiBase(msiBase), .targetFlat(targetFlat),
    .genWrData(genWrData), .cfgRead(cfgRead), .genRead(genRead),
    .busAddr(busAddr), .busData(busData)
  );
endmodule

// File: rtl/msgw_chk.sv
module msgw_chk #(
  parameter int NUM_SRC = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [31:0]        cfgWord,
  input logic               busValid,
  input logic               busReady,
  input logic [31:0]        busAddr,
  input logic [31:0]        busData,
  input logic [NUM_SRC-1:0] pendClr,
  input logic               busy,
  input logic [31:0]        genRead
);
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busReady |=> busValid && $stable(busAddr) && $stable(busData)); // R8
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pendClr)); // R7
  AST_CLR_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (pendClr != '0) |-> busValid && busReady); // R7
  AST_NO_LAUNCH_OFF: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busValid) |-> $past(cfgWord[8]) && $past(cfgWord[2])); // R3
  AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (!rstN)
    busValid || genRead[12] |-> busy); // R12
endmodule

bind msgWriteGen msgw_chk #(.NUM_SRC(NUM_SRC)) uChk (
  .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .busValid(busValid),
  .busReady(busReady), .busAddr(busAddr), .busData(busData),
  .pendClr(pendClr), .busy(busy), .genRead(genRead)
);

// File: tb/tb_msgWriteGen.sv
module tb_msgWriteGen;
  localparam int NS = 4;
  localparam logic [31:0] BASE = 32'h2800_0000;

  logic clk = 0;
  logic rstN = 0;
  logic [31:0] cfgWord = 0, cfgRead, msiBase = BASE;
  logic [NS-1:0] pend = 0, pendSet = 0, benchClr = 0, srcEnable = 0, pendClr;
  logic [32*NS-1:0] targetFlat = 0;
  logic genWrEn = 0;
  logic [31:0] genWrData = 0, genRead, busAddr, busData;
  logic busValid, busReady = 0, busy;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  always @(posedge clk)
    if (!rstN) pend <= 0;
    else pend <= ((pend & ~pendClr) | pendSet) & ~benchClr;

  msgWriteGen #(.NUM_SRC(NS)) dut (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .cfgRead(cfgRead), .msiBase(msiBase),
    .srcPending(pend), .srcEnable(srcEnable), .targetFlat(targetFlat), .pendClr(pendClr),
    .genWrEn(genWrEn), .genWrData(genWrData), .genRead(genRead), .busValid(busValid),
    .busReady(busReady), .busAddr(busAddr), .busData(busData), .busy(busy)
  );

  function automatic logic [31:0] rev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
  function automatic logic [31:0] cfgOf(input logic ie, dm, be);
    return (32'(ie) << 8) | (32'(dm) << 2) | 32'(be);
  endfunction
  function automatic logic [13:0] hartOf(input int s);  return 14'(s * 3 + 1); endfunction
  function automatic logic [5:0]  guestOf(input int s); return 6'(s + 2); endfunction
  function automatic logic [10:0] idOf(input int s);    return 11'(100 + s * 37); endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic takeMsg(input string req, input logic [31:0] expA, input logic [31:0] expD,
                         input logic [NS-1:0] expClr);
    int n = 0;
    while (!busValid && n < 40) begin @(negedge clk); n++; end
    chk({req, " valid"}, 32'(busValid), 32'd1);
    chk({req, " addr"}, busAddr, expA);
    chk({req, " data"}, busData, expD);
    repeat (3) @(negedge clk);
    chk("R8 stall hold", {busAddr[30:0] ^ expA[30:0], busValid}, {31'd0, 1'b1});
    chk("R8 stall data", busData, expD);
    busReady = 1;
    #1;
    chk("R7 clear pulse", 32'(pendClr), 32'(expClr));
    @(negedge clk);
    busReady = 0;
    chk("R7 no clear after", 32'(pendClr), 32'd0);
  endtask

  task automatic pulsePend(input logic [NS-1:0] m);
    pendSet = m; @(negedge clk); pendSet = 0;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    for (int s = 0; s < NS; s++)
      targetFlat[32*s +: 32] = {hartOf(s), guestOf(s), 1'b0, idOf(s)};
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", 32'(busValid), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 status", 32'(genRead[12]), 0);
    chk("R1 clear", 32'(pendClr), 0);

    // R2 readback over all eight combinations of the three config bits
    for (int c = 0; c < 8; c++) begin
      logic [31:0] le;
      cfgWord = cfgOf(c[2], c[1], c[0]) | 32'h0000_F0F2;
      #1;
      le = 32'h8000_0000 | cfgOf(c[2], c[1], c[0]);
      chk("R2 cfg readback", cfgRead, c[0] ? rev(le) : le);
    end

    // R3 disabled or wire mode: no launch
    srcEnable = '1;
    for (int c = 0; c < 3; c++) begin
      cfgWord = cfgOf(c == 1, c == 2, 0);
      pulsePend(4'b0010);
      repeat (6) @(negedge clk);
      chk("R3 no launch when off", 32'(busValid), 0);
      chk("R6 still pending", 32'(pend), 32'b0010);
      benchClr = '1; @(negedge clk); benchClr = 0;
    end

    // R4/R5 each source, both byte orders
    for (int be = 0; be < 2; be++) begin
      cfgWord = cfgOf(1, 1, be[0]);
      for (int s = 0; s < NS; s++) begin
        logic [31:0] a, d;
        a = BASE + (32'(hartOf(s)) << 12) + (32'(guestOf(s)) << 12);
        d = 32'(idOf(s));
        pulsePend(NS'(1) << s);
        takeMsg(be ? "R5 big-endian" : "R4 source msg", a, be ? rev(d) : d, NS'(1) << s);
      end
    end

    // R6 sweep over every enable mask with all sources pending
    cfgWord = cfgOf(1, 1, 0);
    for (int m = 0; m < 16; m++) begin
      srcEnable = NS'(m);
      pulsePend('1);
      for (int s = 0; s < NS; s++)
        if (m[s])
          takeMsg("R6 lowest first",
                  BASE + (32'(hartOf(s)) << 12) + (32'(guestOf(s)) << 12),
                  32'(idOf(s)), NS'(1) << s);
      repeat (4) @(negedge clk);
      chk("R6 disabled silent", 32'(busValid), 0);
      chk("R6 disabled remain", 32'(pend), 32'(~m & 4'hF));
      benchClr = '1; @(negedge clk); benchClr = 0;
    end

    // R9/R10/R11/R12 software message while delivery off
    cfgWord = cfgOf(0, 1, 0);
    srcEnable = '1;
    chk("R12 idle busy", 32'(busy), 0);
    genWrData = (32'd5 << 18) | 32'd7; genWrEn = 1;
    @(negedge clk);
    genWrData = (32'd9 << 18) | 32'd9;
    @(negedge clk);
    genWrEn = 0;
    chk("R9 status set", 32'(genRead[12]), 1);
    chk("R10 readback kept", genRead, (32'd5 << 18) | (32'd1 << 12) | 32'd7);
    chk("R12 busy waiting", 32'(busy), 1);
    chk("R3 sw held off", 32'(busValid), 0);
    pulsePend(4'b0110);
    @(negedge clk);
    cfgWord = cfgOf(1, 1, 1);
    takeMsg("R11 sw first", BASE + (32'd5 << 12), rev(32'd7), 0);
    chk("R9 status clear", 32'(genRead[12]), 0);
    takeMsg("R11 then source", BASE + (32'(hartOf(1)) << 12) + (32'(guestOf(1)) << 12),
            rev(32'(idOf(1))), 4'b0010);
    takeMsg("R11 then source2", BASE + (32'(hartOf(2)) << 12) + (32'(guestOf(2)) << 12),
            rev(32'(idOf(2))), 4'b0100);
    repeat (3) @(negedge clk);
    chk("R12 busy idle", 32'(busy), 0);

    // R9 single software write, little-endian, large hart
    cfgWord = cfgOf(1, 1, 0);
    genWrData = (32'h3FFF << 18) | 32'h7FF; genWrEn = 1;
    @(negedge clk); genWrEn = 0;
    takeMsg("R9 sw message", BASE + (32'h3FFF << 12), 32'h7FF, 0);
    finishRun();
  end
endmodule